// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block counts time-base ticks and watches for software that has stopped servicing it. It does not act on the first missed deadline. Each time the selected period runs out, it moves one step further. The first expiry flags that the watchdog has fired. The second marks a warning and can raise a level interrupt. The third records the configured reset kind in the status word, stops the counter, and sends out a one-cycle reset request that carries that kind.

Software programs a 32-bit control word. Bits 31:30 select the period, bits 29:28 select the reset kind and bit 27 enables the interrupt. Software services the watchdog by writing a clear mask to the status word. Each one in bits 31:28 of the mask clears the matching status bit. Both words can be read back at any time on dedicated outputs. What happens downstream of the reset request is outside this block.

Top module: `wdog_escalate`

## Requirements
- R1: After reset, the control and status outputs read zero, and the interrupt, the reset request and the reset kind are all low.
- R2: Only cycles with `tick` high are counted. With control bits 31:30 equal to `s`, an expiry happens on every 2^(EXP_BASE+EXP_STEP*s)-th counted tick, which gives 2^17, 2^21, 2^25 or 2^29 ticks with the default parameters. The count restarts from zero after each expiry.
- R3: An expiry while status bit 31 is clear sets status bit 31. This holds whether status bit 30 is clear or set.
- R4: An expiry while status bits 31:30 equal 2'b10 sets status bit 30.
- R5: `wd_irq` is high exactly while status bit 30 and control bit 27 are both set.
- R6: An expiry while status bits 31:30 equal 2'b11 copies control bits 29:28 into status bits 29:28. Counting then stops and no further expiries happen.
- R7: At that final expiry, if the reset kind is nonzero, `rst_req` pulses for exactly one cycle with `rst_kind` equal to the kind (1 core, 2 chip, 3 system). A kind of 0 gives no pulse. `rst_kind` reads 0 whenever `rst_req` is low.
- R8: A status clear write clears each status bit 31:28 whose mask bit is one. If it clears bit 31 or bit 30 after the final stage, counting resumes from zero.
- R9: When a status clear and an expiry fall in the same cycle, the clear wins for the bits it names.
- R10: Control bits 31:27 are stored as written. The other control bits and status bits 27:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 32 | Ones in bits 31:28 clear those status bits |
| ctl_q | output | 32 | Control word readback |
| sts_q | output | 32 | Status word readback |
| wd_irq | output | 1 | Watchdog interrupt level |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset kind that goes with the request |

## Verification
The bench builds the block with EXP_BASE=2 and EXP_STEP=1, so the four periods become 4, 8, 16 and 32 ticks. With periods this short, every combination of period, reset kind and interrupt enable can be run through all three stages and past the halt, tick by tick. Directed cases then cover the 01 status path, resuming after a halt, a clear that falls in the same cycle as an expiry, and gaps between ticks.

// File: rtl/wdesc_pkg.sv
package wdesc_pkg;

  typedef struct packed {
    logic       fired;
    logic       warned;
    logic [1:0] kind;
  } wd_status_t;

  // Exponent of the period, in ticks, for a given period select.
  function automatic int unsigned period_exp(input int unsigned base,
                                             input int unsigned step,
                                             input logic [1:0] sel);
    return base + step * int'(sel);
  endfunction

endpackage

// File: rtl/wdesc_period_cnt.sv
module wdesc_period_cnt
  import wdesc_pkg::*;
#(
  parameter int unsigned EXP_BASE = 17,
  parameter int unsigned EXP_STEP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int unsigned CNT_W = EXP_BASE + 3 * EXP_STEP;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit  = {CNT_W{1'b1}} >> (CNT_W - period_exp(EXP_BASE, EXP_STEP, sel));
    expire = tick & run & (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (expire)     cnt <= '0;
    else if (tick & run) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdesc_stage.sv
module wdesc_stage
  import wdesc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic [1:0] ctl_kind,
  input  logic       clr_we,
  input  logic [3:0] clr_mask,
  output wd_status_t st,
  output logic       halted,
  output logic       final_evt,
  output logic       rst_req,
  output logic [1:0] rst_kind
);
  wd_status_t st_nxt;
  logic       halt_nxt;
  logic       resume;

  always_comb begin
    st_nxt    = st;
    final_evt = 1'b0;
    if (expire) begin
      case ({st.fired, st.warned})
        2'b10:   st_nxt.warned = 1'b1;
        2'b11: begin
          st_nxt.kind = ctl_kind;
          final_evt   = 1'b1;
        end
        default: st_nxt.fired = 1'b1;
      endcase
    end
    resume = clr_we & (clr_mask[3] | clr_mask[2]);
    if (clr_we) st_nxt = st_nxt & ~clr_mask;
    halt_nxt = (halted | final_evt) & ~resume;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= '0;
      halted   <= 1'b0;
      rst_req  <= 1'b0;
      rst_kind <= 2'b00;
    end else begin
      st       <= st_nxt;
      halted   <= halt_nxt;
      rst_req  <= final_evt & (ctl_kind != 2'b00);
      rst_kind <= final_evt ? ctl_kind : 2'b00;
    end
  end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdesc_pkg::*;
#(
  parameter int unsigned EXP_BASE = 17,
  parameter int unsigned EXP_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  input  logic        sts_clr_we,
  input  logic [31:0] sts_clr_mask,
  output logic [31:0] ctl_q,
  output logic [31:0] sts_q,
  output logic        wd_irq,
  output logic        rst_req,
  output logic [1:0]  rst_kind
);
  logic [1:0] per_sel;
  logic [1:0] rst_sel;
  logic       irq_en;
  logic       expire;
  logic       final_evt;
  logic       halted;
  wd_status_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_sel <= 2'b00;
      rst_sel <= 2'b00;
      irq_en  <= 1'b0;
    end else if (ctl_we) begin
      per_sel <= ctl_wdata[31:30];
      rst_sel <= ctl_wdata[29:28];
      irq_en  <= ctl_wdata[27];
    end
  end

  wdesc_period_cnt #(.EXP_BASE(EXP_BASE), .EXP_STEP(EXP_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(~halted),
    .sel(per_sel), .expire(expire)
  );

  wdesc_stage u_stage (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ctl_kind(rst_sel),
    .clr_we(sts_clr_we), .clr_mask(sts_clr_mask[31:28]),
    .st(st), .halted(halted), .final_evt(final_evt),
    .rst_req(rst_req), .rst_kind(rst_kind)
  );

  assign ctl_q  = {per_sel, rst_sel, irq_en, 27'd0};
  assign sts_q  = {st, 28'd0};
  assign wd_irq = st.warned & irq_en;
endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        expire,
  input logic        final_evt,
  input logic [31:0] ctl_q,
  input logic [31:0] sts_q,
  input logic        wd_irq,
  input logic        rst_req,
  input logic [1:0]  rst_kind
);
  // R2
  expire_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick);
  // R3
  fired_rises_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[31]) |-> $past(tick));
  // R4
  warn_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[30]) |-> $past(sts_q[31]));
  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> ctl_q[27]);
  // R6
  final_only_from_top_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_evt |-> sts_q[31:30] == 2'b11);
  // R7
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7
  req_kind_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_kind != 2'b00) && (rst_kind == $past(ctl_q[29:28])));
  // R7
  kind_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |-> rst_kind == 2'b00);
endmodule

bind wdog_escalate wdog_escalate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire),
  .final_evt(final_evt), .ctl_q(ctl_q), .sts_q(sts_q), .wd_irq(wd_irq),
  .rst_req(rst_req), .rst_kind(rst_kind)
);

// File: tb/wdog_escalate_tb.sv
module wdog_escalate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        sts_clr_we = 1'b0;
  logic [31:0] sts_clr_mask = '0;
  logic [31:0] ctl_q, sts_q;
  logic        wd_irq, rst_req;
  logic [1:0]  rst_kind;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_escalate #(.EXP_BASE(2), .EXP_STEP(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask), .ctl_q(ctl_q),
    .sts_q(sts_q), .wd_irq(wd_irq), .rst_req(rst_req), .rst_kind(rst_kind)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic write_ctl(input logic [31:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic clr_sts(input logic [31:0] m, input bit with_tick);
    @(negedge clk); sts_clr_we = 1'b1; sts_clr_mask = m; tick = with_tick;
    @(negedge clk); sts_clr_we = 1'b0; tick = 1'b0;
  endtask

  function automatic logic [31:0] exp_sts(input int e, input logic [1:0] kind);
    logic [31:0] v = '0;
    if (e >= 1) v[31] = 1'b1;
    if (e >= 2) v[30] = 1'b1;
    if (e >= 3) v[29:28] = kind;
    return v;
  endfunction

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", ctl_q, 32'h0);
    chk("R1", sts_q, 32'h0);
    chk("R1", {29'd0, wd_irq, rst_req, 1'b0}, 32'h0);
    chk("R1", {30'd0, rst_kind}, 32'h0);

    // Sweep: every period, reset kind and interrupt enable through all stages.
    for (int sel = 0; sel < 4; sel++)
      for (int kind = 0; kind < 4; kind++)
        for (int ie = 0; ie < 2; ie++) begin
          int p;
          p = 1 << (2 + sel);
          do_reset();
          write_ctl({sel[1:0], kind[1:0], ie[0], 27'h5A5_A5A5});
          // R10 low control bits read zero
          chk("R10", ctl_q, {sel[1:0], kind[1:0], ie[0], 27'd0});
          for (int k = 1; k <= 4 * p; k++) begin
            int e;
            bit rq;
            do_tick();
            e  = (k / p > 3) ? 3 : k / p;
            rq = (k == 3 * p) && (kind != 0);
            // R2 R3 R4 R6 stage progression
            chk("R2/R3/R4/R6", sts_q, exp_sts(e, kind[1:0]));
            // R5
            chk("R5", {31'd0, wd_irq}, {31'd0, (e >= 2) && (ie == 1)});
            // R7
            chk("R7", {29'd0, rst_req, rst_kind}, {29'd0, rq, rq ? kind[1:0] : 2'b00});
          end
        end

    // R8: resume after halt (period 4, kind 2)
    do_reset();
    write_ctl({2'b00, 2'b10, 1'b0, 27'd0});
    for (int k = 0; k < 12; k++) do_tick();
    chk("R6", sts_q, 32'hE000_0000);
    clr_sts(32'hF000_0000, 0);
    chk("R8", sts_q, 32'h0);
    for (int k = 0; k < 3; k++) do_tick();
    chk("R8", sts_q, 32'h0);
    do_tick();
    chk("R8", sts_q, 32'h8000_0000);

    // R3 from state 01, R5 level behaviour
    do_reset();
    write_ctl({2'b00, 2'b00, 1'b1, 27'd0});
    for (int k = 0; k < 8; k++) do_tick();
    chk("R5", {31'd0, wd_irq}, 32'd1);
    clr_sts(32'h8000_0000, 0);
    chk("R8", sts_q, 32'h4000_0000);
    chk("R5", {31'd0, wd_irq}, 32'd1);
    for (int k = 0; k < 4; k++) do_tick();
    chk("R3", sts_q, 32'hC000_0000);
    write_ctl(32'h0);
    chk("R5", {31'd0, wd_irq}, 32'd0);
    clr_sts(32'h4000_0000, 0);
    chk("R8", sts_q, 32'h8000_0000);

    // R9 clear in same cycle as expiry; R2 idle gaps do not count
    do_reset();
    write_ctl(32'h0);
    for (int k = 0; k < 3; k++) begin
      do_tick();
      for (int g = 0; g < 5; g++) idle();
    end
    chk("R2", sts_q, 32'h0);
    clr_sts(32'h8000_0000, 1);
    chk("R9", sts_q, 32'h0);
    for (int k = 0; k < 3; k++) do_tick();
    chk("R2", sts_q, 32'h0);
    do_tick();
    chk("R2", sts_q, 32'h8000_0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule